// File: doc/BRIEF.md
# Three-Tap Fractional-Spaced Transmit Equalizer

This block is a digital model of a transmit feed-forward equalizer running on an oversampled serial bit stream. Every UI spans `SPU` sample clocks (8 by default). On each sample clock the block combines three taps into one signed amplitude code that could drive a DAC or a current-steering output stage:
- the current bit, as the main cursor;
- a fractional cursor, which is the same stream delayed by a programmable number of samples, that is, a fraction of a UI;
- a post cursor, which is the stream delayed by exactly one UI.

Both delayed taps are subtracted, so the fractional tap gives de-emphasis with a boost peak above the Nyquist rate. A typical setting is half a UI of delay with a fractional weight of about 0.56 of the main weight. A whole-UI setting pairs with a post weight of about 0.3 of the main weight.

A small control state machine has two states. `ST_PRIME` is a single cycle after reset in which the configuration is captured and the input is not taken. `ST_RUN` is normal operation. The only transitions are `ST_PRIME` to `ST_RUN`, which is unconditional, and `ST_RUN` to itself. During `ST_RUN` a sample-phase counter marks UI boundaries, and the weights and delay take new values only at those boundaries, so a bit never glitches partway through.

Top module: `frac_ffe3`

## Requirements
- R1: While reset is asserted and directly after it is released, `lvl_o` is 0, and all delay-line stages hold bit value 0.
- R2: The first rising clock edge after reset release is the priming cycle (`ST_PRIME`). At that edge the block captures the configuration, does not shift `ser_i` into the delay line, and leaves `lvl_o` at 0.
- R3: After each `ST_RUN` edge, `lvl_o` equals main·s(x) − frac·s(x_d) − post·s(x_U), computed from the sample taken at that edge. Here s(1)=+1 and s(0)=−1, and the weights are unsigned codes. The output therefore has exactly one register of latency.
- R4: The post tap x_U is the sample taken exactly `SPU` sample clocks before the current one.
- R5: The fractional tap x_d is the sample taken exactly D sample clocks before the current one, where D is `cfg_dly_i`, used directly for codes 3 to 6.
- R6: A `cfg_dly_i` code below 3 acts as 3, and a code above 6 acts as 6.
- R7: The configuration present at an `ST_RUN` edge whose sample is the last one of a UI (phase `SPU`−1) applies from the next sample on. Configuration changes at any other phase have no effect on the output.
- R8: With all three weights set to 0, `lvl_o` is 0 for every input pattern.
- R9: The sample phase counts 0 to `SPU`−1 and wraps, so configuration updates happen exactly every `SPU` samples. The first sample after priming has phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, `SPU` ticks per UI |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_i | input | 1 | Oversampled serial bit |
| cfg_main_i | input | WW (6) | Main cursor weight, unsigned |
| cfg_frac_i | input | WW (6) | Fractional cursor weight, unsigned |
| cfg_post_i | input | WW (6) | Post cursor weight, unsigned |
| cfg_dly_i | input | DW (3) | Fractional delay in samples, clamped to 3..6 |
| lvl_o | output | WW+3 (9) | Signed output amplitude code |

## Verification
The main function is tried with four kinds of input:
- UI-wide alternating bits show the combined steady de-emphasis levels.
- Per-sample pseudo-random bits reach every tap combination, which catches a tap picked from the wrong stage.
- Isolated single-tap weight sets separate the main, fractional and post contributions, so an off-by-one delay or a sign error shows on the tap responsible.
- Every delay code from 0 to 7 covers both in-range selection and clamping.

Configuration is also changed in the middle of a UI and on every sample. This tells a correct boundary-only update apart from an immediate one or one taken a sample late.

// File: rtl/frac_ffe3_pkg.sv
package frac_ffe3_pkg;

    // Control states of the equalizer
    typedef enum logic {
        ST_PRIME = 1'b0,   // capture configuration once after reset
        ST_RUN   = 1'b1    // normal sample-by-sample operation
    } ffe_state_e;

    // Signed contribution of one tap: +w for bit 1, -w for bit 0
    function automatic int signed tap_term(input logic bit_v, input int unsigned w);
        return bit_v ? int'(w) : -int'(w);
    endfunction

endpackage

// File: rtl/frac_ffe3_ctl.sv
module frac_ffe3_ctl
    import frac_ffe3_pkg::*;
#(
    parameter int SPU  = 8,
    parameter int WW   = 6,
    parameter int DW   = 3,
    parameter int DMIN = 3,
    parameter int DMAX = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [WW-1:0]                cfg_main_i,
    input  logic [WW-1:0]                cfg_frac_i,
    input  logic [WW-1:0]                cfg_post_i,
    input  logic [DW-1:0]                cfg_dly_i,
    output logic                         run_o,
    output logic [$clog2(SPU)-1:0]       phase_o,
    output logic [WW-1:0]                act_main_o,
    output logic [WW-1:0]                act_frac_o,
    output logic [WW-1:0]                act_post_o,
    output logic [DW-1:0]                act_dly_o
);
    localparam int PW = $clog2(SPU);
    localparam logic [PW-1:0] PH_LAST = PW'(SPU - 1);

    ffe_state_e    state_q, state_d;
    logic [PW-1:0] phase_q;
    logic [DW-1:0] dly_clamped;
    logic          capture;

    // Clamp the requested fractional delay to the supported window
    always_comb begin
        if (int'(cfg_dly_i) < DMIN)      dly_clamped = DW'(DMIN);
        else if (int'(cfg_dly_i) > DMAX) dly_clamped = DW'(DMAX);
        else                             dly_clamped = cfg_dly_i;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PRIME;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
        endcase
    end

    // Configuration is loaded in the priming cycle and on the last sample of each UI
    assign capture = (state_q == ST_PRIME) || (phase_q == PH_LAST);

    // Output-side registers: phase counter and active configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q    <= '0;
            act_main_o <= '0;
            act_frac_o <= '0;
            act_post_o <= '0;
            act_dly_o  <= DW'(DMIN);
        end else begin
            if (state_q == ST_RUN) begin
                phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
            end
            if (capture) begin
                act_main_o <= cfg_main_i;
                act_frac_o <= cfg_frac_i;
                act_post_o <= cfg_post_i;
                act_dly_o  <= dly_clamped;
            end
        end
    end

    assign run_o   = (state_q == ST_RUN);
    assign phase_o = phase_q;

endmodule

// File: rtl/frac_ffe3_dline.sv
module frac_ffe3_dline #(
    parameter int SPU = 8,
    parameter int DW  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_i,
    input  logic          bit_i,
    input  logic [DW-1:0] sel_i,
    output logic          frac_tap_o,
    output logic          post_tap_o
);
    // stage_q[k] holds the sample taken k samples ago
    logic [SPU:1] stage_q;

    for (genvar k = 1; k <= SPU; k++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       stage_q[k] <= 1'b0;
            else if (shift_i) stage_q[k] <= (k == 1) ? bit_i : stage_q[(k == 1) ? 1 : k-1];
        end
    end

    // Fractional tap selection
    always_comb begin
        frac_tap_o = stage_q[1];
        for (int k = 1; k <= SPU; k++) begin
            if (int'(sel_i) == k) frac_tap_o = stage_q[k];
        end
    end

    assign post_tap_o = stage_q[SPU];

endmodule

// File: rtl/frac_ffe3_sum.sv
module frac_ffe3_sum
    import frac_ffe3_pkg::*;
#(
    parameter int WW = 6,
    parameter int OW = WW + 3
) (
    input  logic                 main_bit_i,
    input  logic                 frac_bit_i,
    input  logic                 post_bit_i,
    input  logic [WW-1:0]        w_main_i,
    input  logic [WW-1:0]        w_frac_i,
    input  logic [WW-1:0]        w_post_i,
    output logic signed [OW-1:0] sum_o
);
    int signed acc;

    always_comb begin
        acc = tap_term(main_bit_i, int'(w_main_i))
            - tap_term(frac_bit_i, int'(w_frac_i))
            - tap_term(post_bit_i, int'(w_post_i));
        sum_o = OW'(acc);
    end

endmodule

// File: rtl/frac_ffe3.sv
module frac_ffe3
    import frac_ffe3_pkg::*;
#(
    parameter int SPU  = 8,
    parameter int WW   = 6,
    parameter int DW   = 3,
    parameter int DMIN = 3,
    parameter int DMAX = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ser_i,
    input  logic [WW-1:0]           cfg_main_i,
    input  logic [WW-1:0]           cfg_frac_i,
    input  logic [WW-1:0]           cfg_post_i,
    input  logic [DW-1:0]           cfg_dly_i,
    output logic signed [WW+2:0]    lvl_o
);
    localparam int OW = WW + 3;
    localparam int PW = $clog2(SPU);

    logic                 run;
    logic [PW-1:0]        phase;
    logic [WW-1:0]        act_main, act_frac, act_post;
    logic [DW-1:0]        act_dly;
    logic                 frac_bit, post_bit;
    logic signed [OW-1:0] sum;
    logic signed [OW-1:0] lvl_q;

    frac_ffe3_ctl #(.SPU(SPU), .WW(WW), .DW(DW), .DMIN(DMIN), .DMAX(DMAX)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_main_i (cfg_main_i),
        .cfg_frac_i (cfg_frac_i),
        .cfg_post_i (cfg_post_i),
        .cfg_dly_i  (cfg_dly_i),
        .run_o      (run),
        .phase_o    (phase),
        .act_main_o (act_main),
        .act_frac_o (act_frac),
        .act_post_o (act_post),
        .act_dly_o  (act_dly)
    );

    frac_ffe3_dline #(.SPU(SPU), .DW(DW)) u_dline (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_i    (run),
        .bit_i      (ser_i),
        .sel_i      (act_dly),
        .frac_tap_o (frac_bit),
        .post_tap_o (post_bit)
    );

    frac_ffe3_sum #(.WW(WW), .OW(OW)) u_sum (
        .main_bit_i (ser_i),
        .frac_bit_i (frac_bit),
        .post_bit_i (post_bit),
        .w_main_i   (act_main),
        .w_frac_i   (act_frac),
        .w_post_i   (act_post),
        .sum_o      (sum)
    );

    // Output register: updates only while running
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   lvl_q <= '0;
        else if (run) lvl_q <= sum;
    end

    assign lvl_o = lvl_q;

endmodule

// File: rtl/frac_ffe3_chk.sv
module frac_ffe3_chk #(
    parameter int SPU  = 8,
    parameter int WW   = 6,
    parameter int DW   = 3,
    parameter int DMIN = 3,
    parameter int DMAX = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     run,
    input logic [$clog2(SPU)-1:0]   phase,
    input logic [WW-1:0]            act_main,
    input logic [WW-1:0]            act_frac,
    input logic [WW-1:0]            act_post,
    input logic [DW-1:0]            act_dly,
    input logic signed [WW+2:0]     lvl
);
    localparam int PW = $clog2(SPU);

    // R2
    prime_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (lvl == '0));

    // R6
    dly_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (int'(act_dly) >= DMIN && int'(act_dly) <= DMAX));

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && phase != '0) |-> ($stable(act_main) && $stable(act_frac)
                                  && $stable(act_post) && $stable(act_dly)));

    // R8
    zero_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && act_main == '0 && act_frac == '0 && act_post == '0) |=> (lvl == '0));

    // R9
    phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && phase == PW'(SPU - 1)) |=> (phase == '0));

endmodule

bind frac_ffe3 frac_ffe3_chk #(.SPU(SPU), .WW(WW), .DW(DW), .DMIN(DMIN), .DMAX(DMAX)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .phase    (phase),
    .act_main (act_main),
    .act_frac (act_frac),
    .act_post (act_post),
    .act_dly  (act_dly),
    .lvl      (lvl_o)
);

// File: tb/frac_ffe3_tb_top.sv
module frac_ffe3_tb_top;
    localparam int SPU = 8;
    localparam int WW  = 6;
    localparam int DW  = 3;
    localparam int OW  = WW + 3;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 ser = 1'b0;
    logic [WW-1:0]        wm = '0, wf = '0, wp = '0;
    logic [DW-1:0]        dc = '0;
    logic signed [OW-1:0] lvl;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    hist [0:SPU];
    int    phase;
    int    am, af, ap, ad;
    string req = "R3";
    logic [15:0] lf = 16'hACE1;

    always #4 clk = ~clk;   // 125 MHz

    frac_ffe3 dut_i (
        .clk(clk), .rst_n(rst_n), .ser_i(ser),
        .cfg_main_i(wm), .cfg_frac_i(wf), .cfg_post_i(wp), .cfg_dly_i(dc),
        .lvl_o(lvl)
    );

    function automatic int clampd(int c);
        return (c < 3) ? 3 : ((c > 6) ? 6 : c);
    endfunction

    function automatic int sg(bit b, int w);
        return b ? w : -w;
    endfunction

    task automatic chk(int act, int exp, string r);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: lvl=%0d expected %0d", r, act, exp);
        end
    endtask

    task automatic load_act();
        am = int'(wm); af = int'(wf); ap = int'(wp); ad = clampd(int'(dc));
    endtask

    // R1 / R2: reset, then the priming cycle
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ser   = 1'b1;
        repeat (2) @(posedge clk);
        #2 chk(int'(lvl), 0, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        chk(int'(lvl), 0, "R1");
        @(posedge clk);
        #2 chk(int'(lvl), 0, "R2");
        for (int k = 0; k <= SPU; k++) hist[k] = 1'b0;
        phase = 0;
        load_act();
    endtask

    task automatic step(bit b);
        int exp;
        @(negedge clk);
        ser = b;
        exp = sg(b, am) - sg(hist[ad], af) - sg(hist[SPU], ap);
        @(posedge clk);
        #2 chk(int'(lvl), exp, req);
        for (int k = SPU; k >= 2; k--) hist[k] = hist[k-1];
        hist[1] = b;
        if (phase == SPU - 1) load_act();
        phase = (phase + 1) % SPU;
    endtask

    function automatic bit rnd();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        return lf[0];
    endfunction

    task automatic rand_run(int n);
        for (int i = 0; i < n; i++) step(rnd());
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        summary();
        $finish;
    end

    initial begin
        // Half-UI delay with fractional weight near 0.56 of main
        wm = 6'd50; wf = 6'd28; wp = 6'd0; dc = 3'd4;
        do_reset();

        // R3: UI-wide alternating bits, then isolated pulse, then random samples
        req = "R3";
        for (int u = 0; u < 6; u++) for (int s = 0; s < SPU; s++) step(bit'(u % 2));
        for (int s = 0; s < SPU; s++) step(1'b1);
        for (int s = 0; s < 3*SPU; s++) step(1'b0);
        rand_run(64);

        // R3 with whole-UI de-emphasis near 0.3
        wm = 6'd40; wf = 6'd0; wp = 6'd12;
        rand_run(40);

        // R4: post tap only
        req = "R4";
        wm = 6'd0; wf = 6'd0; wp = 6'd40;
        rand_run(48);

        // R5: fractional tap only, each in-range delay code
        req = "R5";
        for (int c = 3; c <= 6; c++) begin
            wm = 6'd0; wf = 6'd33; wp = 6'd0; dc = DW'(c);
            rand_run(40);
        end

        // R6: out-of-range delay codes are clamped
        req = "R6";
        for (int c = 0; c <= 7; c++) begin
            if (c >= 3 && c <= 6) continue;
            wm = 6'd5; wf = 6'd31; wp = 6'd0; dc = DW'(c);
            rand_run(40);
        end

        // R7: change configuration mid-UI; old values must hold until the boundary
        req = "R7";
        while (phase != 3) step(rnd());
        wm = 6'd63; wf = 6'd17; wp = 6'd9; dc = 3'd5;
        rand_run(4);
        while (phase != 5) step(rnd());
        wm = 6'd2; wf = 6'd44; wp = 6'd21; dc = 3'd3;
        rand_run(20);

        // R9: configuration changed on every sample lands exactly every SPU samples
        req = "R9";
        for (int i = 0; i < 4*SPU; i++) begin
            wm = WW'(i * 7 + 3);
            wf = WW'(i * 5 + 1);
            wp = WW'(i * 3);
            dc = DW'(i);
            step(rnd());
        end

        // R8: zero weights give a zero output
        req = "R8";
        wm = '0; wf = '0; wp = '0; dc = 3'd4;
        rand_run(2*SPU);
        rand_run(24);

        // Reset mid-stream at full weights, then resume
        wm = 6'd63; wf = 6'd63; wp = 6'd63; dc = 3'd6;
        do_reset();
        req = "R3";
        for (int s = 0; s < 2*SPU; s++) step(1'b1);
        rand_run(48);

        summary();
        $finish;
    end

endmodule